// File: doc/BRIEF.md
# Watchdog Counter with Overflow-Timed Reset Hold

This block is a free-running supervision counter for a small controller. Software arms it by setting an enable bit in a control word. Each strobe on a prescaled count-enable input then advances the counter by one. Software keeps the system alive by reloading the counter before it wraps.

If the counter wraps anyway, the block records the event in a status flag and raises a level reset-hold output that keeps the rest of the chip in reset. The counter keeps running during the hold. Its next wrap drops the hold and emits a one-cycle request that starts the same reset exception sequence an external reset pin would. The hold therefore lasts exactly one full counter period.

The flag survives the release, so the restarted software can tell a watchdog reset from a cold start.

Top module: `wdt_ovf_reset`

## Requirements
- R1: After the synchronous reset input `rst`, the counter is 0, the enable bit and the status flag are 0, and `rst_hold` and `exc_start` are 0.
- R2: The counter advances by one on each cycle with `tick`=1 only while the enable bit (control bit 0) is 1. Ticks with the enable bit at 0 leave the counter unchanged.
- R3: A write with `wr_sel`=1 loads `wr_data` into the counter. It wins over a tick in the same cycle, and that cycle never counts as an overflow.
- R4: An overflow is an enabled tick while the counter holds its all-ones value. The counter then wraps to 0. If `rst_hold` is low, the status flag (control bit 1) becomes 1 and `rst_hold` rises in the following cycle.
- R5: While `rst_hold` is high, the counter keeps counting. The next overflow drops `rst_hold` and raises `exc_start` for exactly one cycle, on the same edge.
- R6: `rst_hold` stays high for exactly 2^CNT_W ticks after the tick that raised it.
- R7: While `rst_hold` is high, every register write is ignored, both to the counter and to the control word.
- R8: A control write (`wr_sel`=0) sets the enable bit from `wr_data` bit 0. Writing 0 to bit 1 clears the status flag, and writing 1 to bit 1 has no effect. The flag stays 1 after the hold is released.
- R9: `rst` asserted while the hold is active clears the counter, the enable bit, the flag and the hold at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on / pin reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control word, 1 counter |
| wr_data | input | CNT_W | Write data (control: bit 0 enable, bit 1 flag clear-by-zero) |
| tick | input | 1 | Prescaled count-enable strobe |
| cnt_q | output | CNT_W | Current counter value |
| ctrl_q | output | 2 | Control readback: bit 0 enable, bit 1 status flag |
| rst_hold | output | 1 | Level reset hold to the rest of the chip |
| exc_start | output | 1 | One-cycle reset-exception start request |

## Verification
The bench builds the block with CNT_W = 4. A complete hold period is then only sixteen ticks, so both overflows, the release pulse and the exact hold length fall within a short directed run. It also brings the all-ones preload, a write colliding with a tick, and writes during the hold within reach in a few vectors. The same logic is parameter-independent, so these cases carry over to the default 8-bit width.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_FLAG_BIT = 1;

    typedef struct packed {
        logic flag;
        logic en;
    } wdt_ctrl_t;

    typedef enum logic {
        TGT_CTRL  = 1'b0,
        TGT_COUNT = 1'b1
    } wdt_target_e;

    function automatic logic is_wrap(input logic run, input logic tick,
                                     input logic load, input logic all_ones);
        return run && tick && !load && all_ones;
    endfunction

endpackage

// File: rtl/wdt_count_unit.sv
module wdt_count_unit
    import wdt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt;
        if (load)
            cnt_d = load_val;
        else if (run && tick)
            cnt_d = cnt + 1'b1;
    end

    assign ovf = is_wrap(run, tick, load, cnt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_d;
    end

    // R2: idle counter stays put
    assert_idle_stable_R2: assert property (@(posedge clk) disable iff (rst)
        (!run && !load) |=> $stable(cnt));
    // R3: load takes effect next cycle
    assert_load_value_R3: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt == $past(load_val));
    // R4: overflow leaves counter at zero
    assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (rst)
        ovf |=> cnt == '0);

endmodule

// File: rtl/wdt_hold_ctrl.sv
module wdt_hold_ctrl
    import wdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ovf,
    input  logic      ctrl_wr,
    input  logic      wr_en_bit,
    input  logic      wr_flag_bit,
    output wdt_ctrl_t ctrl,
    output logic      hold,
    output logic      exc_pulse
);
    wdt_ctrl_t ctrl_d;
    logic      enter, leave;

    assign enter = ovf && !hold;
    assign leave = ovf && hold;

    always_comb begin
        ctrl_d = ctrl;
        if (ctrl_wr) begin
            ctrl_d.en = wr_en_bit;
            if (!wr_flag_bit) ctrl_d.flag = 1'b0;
        end
        if (enter) ctrl_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            hold      <= 1'b0;
            exc_pulse <= 1'b0;
        end else begin
            ctrl      <= ctrl_d;
            hold      <= hold ^ ovf;
            exc_pulse <= leave;
        end
    end

    // R4: hold entry always marks the flag
    assert_entry_flag_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(hold) |-> ctrl.flag);
    // R5: release request lasts one cycle
    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (rst)
        exc_pulse |=> !exc_pulse);
    // R5: release request coincides with hold dropping
    assert_pulse_on_release_R5: assert property (@(posedge clk) disable iff (rst)
        exc_pulse |-> (!hold && $past(hold)));
    // R8: flag persists through release
    assert_flag_kept_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(hold) |-> ctrl.flag);

endmodule

// File: rtl/wdt_ovf_reset.sv
module wdt_ovf_reset
    import wdt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_q,
    output logic [1:0]       ctrl_q,
    output logic             rst_hold,
    output logic             exc_start
);
    wdt_ctrl_t ctrl;
    logic      hold, ovf;
    logic      cnt_load, ctrl_wr;

    assign cnt_load = wr_en && !hold && (wdt_target_e'(wr_sel) == TGT_COUNT);
    assign ctrl_wr  = wr_en && !hold && (wdt_target_e'(wr_sel) == TGT_CTRL);

    wdt_count_unit #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (wr_data),
        .run      (ctrl.en),
        .tick     (tick),
        .cnt      (cnt_q),
        .ovf      (ovf)
    );

    wdt_hold_ctrl u_hold (
        .clk         (clk),
        .rst         (rst),
        .ovf         (ovf),
        .ctrl_wr     (ctrl_wr),
        .wr_en_bit   (wr_data[CTRL_EN_BIT]),
        .wr_flag_bit (wr_data[CTRL_FLAG_BIT]),
        .ctrl        (ctrl),
        .hold        (hold),
        .exc_pulse   (exc_start)
    );

    assign ctrl_q   = {ctrl.flag, ctrl.en};
    assign rst_hold = hold;

    // R7: control writes during hold have no effect on enable
    assert_hold_blocks_ctrl_R7: assert property (@(posedge clk) disable iff (rst)
        (hold && wr_en && !wr_sel) |=> $stable(ctrl_q[CTRL_EN_BIT]));

endmodule

// File: tb/tb_wdt_ovf_reset.sv
module tb_wdt_ovf_reset;
    localparam int W = 4;

    logic clk = 1'b0;
    logic rst, wr_en, wr_sel, tick;
    logic [W-1:0] wr_data;
    logic [W-1:0] cnt_q;
    logic [1:0]   ctrl_q;
    logic         rst_hold, exc_start;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    wdt_ovf_reset #(.CNT_W(W)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .tick(tick), .cnt_q(cnt_q), .ctrl_q(ctrl_q),
        .rst_hold(rst_hold), .exc_start(exc_start)
    );

    // op: 0 idle, 1 control write, 2 counter write
    typedef struct packed {
        logic [1:0]   op;
        logic [W-1:0] data;
        logic         tk;
        logic [W-1:0] cnt;
        logic         en;
        logic         flag;
        logic         hold;
        logic         pulse;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 4'd1,  1'b0, 4'd0,  1'b1, 1'b0, 1'b0, 1'b0}, // R8 enable
        '{2'd0, 4'd0,  1'b1, 4'd1,  1'b1, 1'b0, 1'b0, 1'b0}, // R2
        '{2'd0, 4'd0,  1'b1, 4'd2,  1'b1, 1'b0, 1'b0, 1'b0}, // R2
        '{2'd2, 4'd14, 1'b1, 4'd14, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 load beats tick
        '{2'd0, 4'd0,  1'b1, 4'd15, 1'b1, 1'b0, 1'b0, 1'b0}, // R2
        '{2'd0, 4'd0,  1'b1, 4'd0,  1'b1, 1'b1, 1'b1, 1'b0}, // R4 first wrap
        '{2'd2, 4'd5,  1'b1, 4'd1,  1'b1, 1'b1, 1'b1, 1'b0}, // R7 count write ignored
        '{2'd1, 4'd0,  1'b0, 4'd1,  1'b1, 1'b1, 1'b1, 1'b0}  // R7 ctrl write ignored
    };

    task automatic step(input logic [1:0] op, input logic [W-1:0] d, input logic tk);
        wr_en   = (op != 2'd0);
        wr_sel  = (op == 2'd2);
        wr_data = d;
        tick    = tk;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; tick = 1'b0;
    endtask

    task automatic chk(input string req, input logic [W-1:0] ec, input logic ee,
                       input logic ef, input logic eh, input logic ep);
        n_chk++;
        if (cnt_q !== ec || ctrl_q !== {ef, ee} || rst_hold !== eh || exc_start !== ep) begin
            n_bad++;
            $display("FAIL %s: got cnt=%0d ctrl=%b hold=%b pulse=%b, expected cnt=%0d ctrl=%b hold=%b pulse=%b",
                     req, cnt_q, ctrl_q, rst_hold, exc_start, ec, {ef, ee}, eh, ep);
        end
    endtask

    initial begin
        #150000;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; tick = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        chk("R1", 0, 0, 0, 0, 0);

        // R2: ticks while disabled do nothing
        step(2'd0, 0, 1'b1);
        step(2'd0, 0, 1'b1);
        chk("R2", 0, 0, 0, 0, 0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].op, VEC[i].data, VEC[i].tk);
            chk($sformatf("vector %0d", i), VEC[i].cnt, VEC[i].en, VEC[i].flag,
                VEC[i].hold, VEC[i].pulse);
        end

        // R6: one tick already spent inside hold; 14 more keep it high
        for (int i = 0; i < 14; i++) step(2'd0, 0, 1'b1);
        chk("R6", 15, 1, 1, 1, 0);
        step(2'd0, 0, 1'b1);
        chk("R5", 0, 1, 1, 0, 1);
        step(2'd0, 0, 1'b0);
        chk("R5", 0, 1, 1, 0, 0);

        // R8: flag survives; writing 1 to bit 1 keeps it, writing 0 clears it
        step(2'd1, 4'b0011, 1'b0);
        chk("R8", 0, 1, 1, 0, 0);
        step(2'd1, 4'b0001, 1'b0);
        chk("R8", 0, 1, 0, 0, 0);

        // R2: disable and tick
        step(2'd2, 4'd7, 1'b0);
        step(2'd1, 4'b0000, 1'b0);
        step(2'd0, 0, 1'b1);
        step(2'd0, 0, 1'b1);
        chk("R2", 7, 0, 0, 0, 0);

        // R3: load all-ones with tick is not an overflow
        step(2'd1, 4'b0001, 1'b0);
        step(2'd2, 4'd15, 1'b1);
        chk("R3", 15, 1, 0, 0, 0);

        // R9: enter hold then pin reset
        step(2'd0, 0, 1'b1);
        chk("R4", 0, 1, 1, 1, 0);
        step(2'd0, 0, 1'b1);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        chk("R9", 0, 0, 0, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule